// File: doc/BRIEF.md
# Hashed Inverted Page Table Walker

This block translates a virtual page number, tagged with a process identifier, into a physical frame number. It does this by searching an inverted page table held in a local memory. The table has one entry for each physical frame, so its size is set by the number of frames alone. It does not grow with the virtual address space or with the number of processes.

A lookup starts by hashing the page number and the process identifier into a start index. The walker reads one entry per cycle. It compares the stored page number and process identifier with the key. On a mismatch it moves to the next index given by that entry's chain pointer. A match returns the entry's own index as the frame number. Any of the following ends the walk with a fault:
- reaching the end of the chain,
- probing an entry marked invalid,
- using up a probe budget equal to the table size.

Software fills the table through a plain write port.

Top module: `frame_lookup_engine`

## Requirements
- R1: While reset is held and after its release, with no request issued, `lk_busy`, `lk_done`, `lk_hit` and `lk_dirty` are 0, and `lk_frame` and `lk_probes` are 0.
- R2: The first entry probed is at index `lk_vpn[5:0] XOR {2'b00, lk_pid}`, with the default 64 entries and a 4-bit process identifier.
- R3: An entry matches only when its valid bit is 1 and both its stored page number and its stored process identifier equal the key. A stored page number that is equal but paired with a different process identifier does not match.
- R4: After a mismatch, the next index probed is the low 6 bits of the mismatching entry's chain pointer. `lk_done` pulses for one cycle exactly N cycles after the edge that accepted the request, where N is the reported probe count.
- R5: A mismatching entry whose 7-bit chain pointer has its top bit set ends the walk. The all-ones value 7'h7F is the end marker. The result is a fault: `lk_hit`=0 and `lk_frame`=0, and `lk_probes` counts every entry read.
- R6: Probing an entry whose valid bit is 0 ends the walk at once with a fault.
- R7: A walk that has made 64 probes without ending (for example on a cyclic chain) ends with a fault and `lk_probes`=64.
- R8: A request raised while `lk_busy` is 1 is ignored. The walk in progress completes with its own result, and no second `lk_done` follows.
- R9: A write with `wr_en`=1 stores the entry fields at `wr_idx`. The next lookup sees the new contents, including overwriting a valid entry with an invalid one.
- R10: On a hit, `lk_frame` is the index of the matching entry and `lk_dirty` is that entry's stored dirty bit. Result outputs hold their value until the next `lk_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Start a lookup (taken only when idle) |
| lk_vpn | input | 10 | Virtual page number to translate |
| lk_pid | input | 4 | Process identifier of the request |
| lk_busy | output | 1 | Walk in progress |
| lk_done | output | 1 | One-cycle pulse: result outputs updated |
| lk_hit | output | 1 | 1 = translation found, 0 = fault |
| lk_dirty | output | 1 | Dirty bit of the matching entry |
| lk_frame | output | 6 | Frame number (index of matching entry) |
| lk_probes | output | 7 | Number of table reads the walk used |
| wr_en | input | 1 | Write one table entry |
| wr_idx | input | 6 | Entry index to write |
| wr_vpn | input | 10 | Stored virtual page number |
| wr_pid | input | 4 | Stored process identifier |
| wr_valid | input | 1 | Stored valid bit |
| wr_dirty | input | 1 | Stored dirty bit |
| wr_chain | input | 7 | Stored chain pointer (top bit set = end) |

## Verification
The assertions assume that software does not write the entry the walker is reading in the same cycle. They also assume the key is only sampled on the accepting edge, so it may change freely at any other time. The stimulus meets the first assumption by loading the whole table before any lookup and by doing later writes only while the walker is idle. It deliberately raises a request in the middle of a long walk so that the rule about ignoring requests is exercised, not merely assumed. Chains are built so that each walk exercises a known path: a single read, two-deep and three-deep collisions, an end marker, an invalid entry, and a two-entry cycle that runs into the probe limit.

// File: rtl/fle_pkg.sv
package fle_pkg;

    // Default geometry of the table
    localparam int unsigned FLE_NFRAMES = 64;
    localparam int unsigned FLE_VPN_W   = 10;
    localparam int unsigned FLE_PID_W   = 4;

    // Walker control states
    typedef enum logic [0:0] {
        WK_IDLE = 1'b0,
        WK_PROBE = 1'b1
    } walk_state_e;

    // Chain pointer carries one bit above the index; that bit set means end
    function automatic int unsigned chain_width(input int unsigned idx_w);
        return idx_w + 1;
    endfunction

endpackage

// File: rtl/fle_hash.sv
module fle_hash #(
    parameter int unsigned IDX_W = 6,
    parameter int unsigned PID_W = 4
) (
    input  logic [IDX_W-1:0] vpn_lo,
    input  logic [PID_W-1:0] pid,
    output logic [IDX_W-1:0] start_idx
);
    // Fold the identifier into index-sized chunks, then XOR with the page bits
    localparam int unsigned NCHUNK = (PID_W + IDX_W - 1) / IDX_W;
    localparam int unsigned PADW   = NCHUNK * IDX_W;

    logic [PADW-1:0] pid_pad;
    assign pid_pad = PADW'(pid);

    always_comb begin
        start_idx = vpn_lo;
        for (int i = 0; i < int'(NCHUNK); i++) begin
            start_idx = start_idx ^ pid_pad[i*IDX_W +: IDX_W];
        end
    end
endmodule

// File: rtl/fle_table.sv
module fle_table #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned ENT_W = 23,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [ENT_W-1:0] wr_data,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [ENT_W-1:0] rd_data
);
    logic [ENT_W-1:0] mem [DEPTH];

    // One write and one synchronous read per cycle; read returns the old word
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
        if (rd_en) begin
            rd_data <= mem[rd_idx];
        end
    end
endmodule

// File: rtl/fle_walker.sv
module fle_walker
    import fle_pkg::*;
#(
    parameter int unsigned NFRAMES = 64,
    parameter int unsigned VPN_W   = 10,
    parameter int unsigned PID_W   = 4,
    localparam int unsigned IDX_W  = $clog2(NFRAMES),
    localparam int unsigned CHN_W  = IDX_W + 1,
    localparam int unsigned CNT_W  = $clog2(NFRAMES + 1),
    localparam int unsigned ENT_W  = 2 + PID_W + VPN_W + CHN_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [VPN_W-1:0] req_vpn,
    input  logic [PID_W-1:0] req_pid,
    input  logic [IDX_W-1:0] start_idx,
    output logic             rd_en,
    output logic [IDX_W-1:0] rd_idx,
    input  logic [ENT_W-1:0] rd_data,
    output logic             busy,
    output logic             done,
    output logic             hit,
    output logic             dirty,
    output logic [IDX_W-1:0] frame,
    output logic [CNT_W-1:0] probes
);
    typedef struct packed {
        logic             valid;
        logic             dirty;
        logic [PID_W-1:0] pid;
        logic [VPN_W-1:0] vpn;
        logic [CHN_W-1:0] chain;
    } entry_t;

    walk_state_e       state;
    logic [VPN_W-1:0]  key_vpn;
    logic [PID_W-1:0]  key_pid;
    logic [IDX_W-1:0]  cur_idx;
    logic [CNT_W-1:0]  cnt;

    entry_t ent;
    logic   match;
    logic   at_end;
    logic   at_limit;
    logic   stop;

    assign ent      = entry_t'(rd_data);
    assign match    = ent.valid && (ent.vpn == key_vpn) && (ent.pid == key_pid);
    assign at_end   = ent.chain[CHN_W-1];
    assign at_limit = (cnt == CNT_W'(NFRAMES));
    assign stop     = match || !ent.valid || at_end || at_limit;
    assign busy     = (state == WK_PROBE);

    // Read issue: start index on accept, chain target while walking on
    always_comb begin
        rd_en  = 1'b0;
        rd_idx = start_idx;
        if (state == WK_IDLE) begin
            rd_en = req_valid;
        end else if (!stop) begin
            rd_en  = 1'b1;
            rd_idx = ent.chain[IDX_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= WK_IDLE;
            key_vpn <= '0;
            key_pid <= '0;
            cur_idx <= '0;
            cnt     <= '0;
            done    <= 1'b0;
            hit     <= 1'b0;
            dirty   <= 1'b0;
            frame   <= '0;
            probes  <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                WK_IDLE: begin
                    if (req_valid) begin
                        key_vpn <= req_vpn;
                        key_pid <= req_pid;
                        cur_idx <= start_idx;
                        cnt     <= CNT_W'(1);
                        state   <= WK_PROBE;
                    end
                end
                WK_PROBE: begin
                    if (stop) begin
                        done   <= 1'b1;
                        hit    <= match;
                        dirty  <= match && ent.dirty;
                        frame  <= match ? cur_idx : '0;
                        probes <= cnt;
                        state  <= WK_IDLE;
                    end else begin
                        cur_idx <= ent.chain[IDX_W-1:0];
                        cnt     <= cnt + CNT_W'(1);
                    end
                end
                default: state <= WK_IDLE;
            endcase
        end
    end

    // R4: the completion flag is a single-cycle pulse
    p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R4: every compare cycle is fed by a read issued on the previous edge
    p_read_feeds_probe_r4: assert property (@(posedge clk) disable iff (rst)
        busy |-> $past(rd_en));

    // R8: the key is frozen while a walk is in progress
    p_busy_holds_key_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && req_valid) |=> ($stable(key_vpn) && $stable(key_pid)));

    // R7: the probe counter never exceeds the table size
    p_probe_bound_r7: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(NFRAMES));

    // R5: a fault reports frame zero
    p_fault_frame_r5: assert property (@(posedge clk) disable iff (rst)
        (done && !hit) |-> (frame == '0));

    // R10: results hold between completions
    p_result_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!done && $past(!rst)) |-> ($stable(hit) && $stable(frame) && $stable(probes)));

    // R3: a completion always reports at least one probe
    p_probe_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
        done |-> (probes != '0));
endmodule

// File: rtl/frame_lookup_engine.sv
module frame_lookup_engine
    import fle_pkg::*;
#(
    parameter int unsigned NFRAMES = FLE_NFRAMES,
    parameter int unsigned VPN_W   = FLE_VPN_W,
    parameter int unsigned PID_W   = FLE_PID_W,
    localparam int unsigned IDX_W  = $clog2(NFRAMES),
    localparam int unsigned CHN_W  = chain_width(IDX_W),
    localparam int unsigned CNT_W  = $clog2(NFRAMES + 1),
    localparam int unsigned ENT_W  = 2 + PID_W + VPN_W + CHN_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lk_req,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic [PID_W-1:0] lk_pid,
    output logic             lk_busy,
    output logic             lk_done,
    output logic             lk_hit,
    output logic             lk_dirty,
    output logic [IDX_W-1:0] lk_frame,
    output logic [CNT_W-1:0] lk_probes,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [PID_W-1:0] wr_pid,
    input  logic             wr_valid,
    input  logic             wr_dirty,
    input  logic [CHN_W-1:0] wr_chain
);
    logic [IDX_W-1:0] start_idx;
    logic             rd_en;
    logic [IDX_W-1:0] rd_idx;
    logic [ENT_W-1:0] rd_data;
    logic [ENT_W-1:0] wr_data;

    // Field order must match the walker's entry layout
    assign wr_data = {wr_valid, wr_dirty, wr_pid, wr_vpn, wr_chain};

    fle_hash #(
        .IDX_W (IDX_W),
        .PID_W (PID_W)
    ) u_hash (
        .vpn_lo    (lk_vpn[IDX_W-1:0]),
        .pid       (lk_pid),
        .start_idx (start_idx)
    );

    fle_table #(
        .DEPTH (NFRAMES),
        .ENT_W (ENT_W)
    ) u_table (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    fle_walker #(
        .NFRAMES (NFRAMES),
        .VPN_W   (VPN_W),
        .PID_W   (PID_W)
    ) u_walker (
        .clk       (clk),
        .rst       (rst),
        .req_valid (lk_req),
        .req_vpn   (lk_vpn),
        .req_pid   (lk_pid),
        .start_idx (start_idx),
        .rd_en     (rd_en),
        .rd_idx    (rd_idx),
        .rd_data   (rd_data),
        .busy      (lk_busy),
        .done      (lk_done),
        .hit       (lk_hit),
        .dirty     (lk_dirty),
        .frame     (lk_frame),
        .probes    (lk_probes)
    );

    // R2: a request accepted while idle reads the hashed start index
    p_start_read_r2: assert property (@(posedge clk) disable iff (rst)
        (lk_req && !lk_busy) |-> (rd_en && rd_idx == start_idx));

    // R9: a write and a walk read never target the same entry in one cycle
    p_no_rw_clash_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rd_en) |-> (wr_idx != rd_idx));
endmodule

// File: tb/tb_frame_lookup_engine.sv
module tb_frame_lookup_engine;
    localparam int CLK_PERIOD = 10;
    localparam logic [6:0] ENDP = 7'h7F;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       lk_req = 1'b0;
    logic [9:0] lk_vpn = '0;
    logic [3:0] lk_pid = '0;
    logic       lk_busy, lk_done, lk_hit, lk_dirty;
    logic [5:0] lk_frame;
    logic [6:0] lk_probes;
    logic       wr_en = 1'b0;
    logic [5:0] wr_idx = '0;
    logic [9:0] wr_vpn = '0;
    logic [3:0] wr_pid = '0;
    logic       wr_valid = 1'b0;
    logic       wr_dirty = 1'b0;
    logic [6:0] wr_chain = '0;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    frame_lookup_engine dut (
        .clk(clk), .rst(rst),
        .lk_req(lk_req), .lk_vpn(lk_vpn), .lk_pid(lk_pid),
        .lk_busy(lk_busy), .lk_done(lk_done), .lk_hit(lk_hit),
        .lk_dirty(lk_dirty), .lk_frame(lk_frame), .lk_probes(lk_probes),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_pid(wr_pid),
        .wr_valid(wr_valid), .wr_dirty(wr_dirty), .wr_chain(wr_chain)
    );

    // Vector: {vpn[10], pid[4], hit, dirty, frame[6], probes[7]}
    localparam int NV = 12;
    localparam logic [28:0] VEC [NV] = '{
        {10'h005, 4'h0, 1'b1, 1'b0, 6'd5,  7'd1},  // R3 direct hit
        {10'h045, 4'h0, 1'b1, 1'b0, 6'd20, 7'd2},  // R4 one collision
        {10'h084, 4'h1, 1'b1, 1'b0, 6'd33, 7'd3},  // R4 two collisions
        {10'h105, 4'h0, 1'b0, 1'b0, 6'd0,  7'd3},  // R5 chain end
        {10'h005, 4'h3, 1'b0, 1'b0, 6'd0,  7'd1},  // R6 invalid start
        {10'h03F, 4'hF, 1'b1, 1'b1, 6'd48, 7'd1},  // R2 R10 dirty hit
        {10'h03F, 4'hE, 1'b0, 1'b0, 6'd0,  7'd1},  // R6 invalid start
        {10'h00A, 4'h2, 1'b1, 1'b0, 6'd10, 7'd2},  // R4 chain hit
        {10'h008, 4'h2, 1'b0, 1'b0, 6'd0,  7'd1},  // R5 end at start
        {10'h00A, 4'h0, 1'b0, 1'b0, 6'd0,  7'd1},  // R3 pid mismatch
        {10'h3C0, 4'h0, 1'b1, 1'b0, 6'd0,  7'd1},  // R2 index 0
        {10'h03F, 4'h0, 1'b1, 1'b0, 6'd63, 7'd1}   // R2 index 63
    };

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic put(input int idx, input logic [9:0] vpn, input logic [3:0] pid,
                       input logic v, input logic d, input logic [6:0] chn);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 6'(idx); wr_vpn = vpn; wr_pid = pid;
        wr_valid = v; wr_dirty = d; wr_chain = chn;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Issue a lookup; optionally raise a second request at cycle inj
    task automatic lookup(input logic [9:0] vpn, input logic [3:0] pid,
                          input int inj, output int lat);
        @(negedge clk);
        lk_req = 1'b1; lk_vpn = vpn; lk_pid = pid;
        @(negedge clk);
        lk_req = 1'b0;
        lat = 0;
        while (!lk_done && lat < 500) begin
            if (inj != 0 && lat == inj) begin
                lk_req = 1'b1; lk_vpn = 10'h005; lk_pid = 4'h0;
            end else begin
                lk_req = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        lk_req = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int lat;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 busy", lk_busy, 0);
        chk("R1 done", lk_done, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 hit", lk_hit, 0);
        chk("R1 dirty", lk_dirty, 0);
        chk("R1 frame", lk_frame, 0);
        chk("R1 probes", lk_probes, 0);

        // R9: load table, all invalid first
        for (int i = 0; i < 64; i++) put(i, 10'h0, 4'h0, 1'b0, 1'b0, ENDP);
        put(5,  10'h005, 4'h0, 1'b1, 1'b0, 7'd20);
        put(20, 10'h045, 4'h0, 1'b1, 1'b0, 7'd33);
        put(33, 10'h084, 4'h1, 1'b1, 1'b0, ENDP);
        put(48, 10'h03F, 4'hF, 1'b1, 1'b1, ENDP);
        put(8,  10'h008, 4'h0, 1'b1, 1'b0, 7'd10);
        put(10, 10'h00A, 4'h2, 1'b1, 1'b0, ENDP);
        put(0,  10'h3C0, 4'h0, 1'b1, 1'b0, ENDP);
        put(63, 10'h03F, 4'h0, 1'b1, 1'b0, ENDP);
        put(40, 10'h068, 4'h0, 1'b1, 1'b0, 7'd41);
        put(41, 10'h069, 4'h0, 1'b1, 1'b0, 7'd40);

        for (int v = 0; v < NV; v++) begin
            lookup(VEC[v][28:19], VEC[v][18:15], 0, lat);
            chk($sformatf("R3 R5 hit v%0d", v), lk_hit, VEC[v][14]);
            chk($sformatf("R10 dirty v%0d", v), lk_dirty, VEC[v][13]);
            chk($sformatf("R10 frame v%0d", v), lk_frame, VEC[v][12:7]);
            chk($sformatf("R4 probes v%0d", v), lk_probes, VEC[v][6:0]);
            chk($sformatf("R4 latency v%0d", v), lat, VEC[v][6:0]);
        end

        // R10: results hold after done
        repeat (3) @(negedge clk);
        chk("R10 hold frame", lk_frame, 63);

        // R7 and R8: cyclic chain hits the probe limit; mid-walk request ignored
        lookup(10'h028, 4'h0, 5, lat);
        chk("R7 hit", lk_hit, 0);
        chk("R7 probes", lk_probes, 64);
        chk("R7 latency", lat, 64);
        chk("R8 result kept", lk_frame, 0);
        lat = 0;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            if (lk_done) lat++;
        end
        chk("R8 no second done", lat, 0);
        chk("R8 idle", lk_busy, 0);

        // R9: overwrite invalid entry 6, then invalidate it again
        put(6, 10'h005, 4'h3, 1'b1, 1'b1, ENDP);
        lookup(10'h005, 4'h3, 0, lat);
        chk("R9 new hit", lk_hit, 1);
        chk("R9 new frame", lk_frame, 6);
        chk("R9 new dirty", lk_dirty, 1);
        put(6, 10'h005, 4'h3, 1'b0, 1'b0, ENDP);
        lookup(10'h005, 4'h3, 0, lat);
        chk("R9 invalidated", lk_hit, 0);
        chk("R6 probes", lk_probes, 1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule